// File: doc/BRIEF.md
# Overlapping 1-0-1 serial pattern detector

This block watches a single serial data bit that arrives once per clock. When the three most recently accepted bits are 1, 0 and 1, in that order, it raises a one-bit flag. Matches may overlap, so the trailing 1 of one match can serve as the leading 1 of the next. The flag is a Moore output: it is decoded from the current state only. It therefore appears in the clock cycle after the edge that accepted the final 1, and it does not follow the input combinationally.

The controller is a fixed four-state graph. A redundant "seen 1-0" state has already been folded into its twin.
- IDLE: no useful prefix has been seen.
- GOT1: the last bit accepted was a 1.
- GOT10: the last two bits accepted were 1 then 0.
- FOUND: a match has just completed. This is the only state that drives the flag.

The transitions are:
- IDLE stays in IDLE on 0 and moves to GOT1 on 1.
- GOT1 moves to GOT10 on 0 and stays in GOT1 on 1.
- GOT10 returns to IDLE on 0 and moves to FOUND on 1.
- FOUND moves back to GOT10 on 0 and moves to GOT1 on 1.

A synchronous active-high reset returns the machine to IDLE.

Top module: `pd101_detector`

## Requirements
- R1: A synchronous reset that is high at a clock edge puts the machine in IDLE. In the following cycle the flag `z` is 0, and bits accepted before the reset cannot contribute to a later match.
- R2: After each clock edge, `z` is 1 exactly when the last three bits accepted since reset were 1, 0, 1, with the oldest bit first. Any bit position that reset left unfilled counts as 0.
- R3: Overlapping matches are all reported. The input stream 1,0,1,0,1 raises `z` after its third bit and again after its fifth bit.
- R4: From FOUND, a 0 moves the machine to GOT10 and a 1 moves it to GOT1. As a result, a FOUND-then-0-then-1 sequence raises `z` again, and a FOUND-then-1-then-0-then-1 sequence raises `z` again.
- R5: A run of 1s holds the machine in GOT1, and two consecutive 0s return it to IDLE. Streams of all 1s, all 0s, or 1,0,0,1 never raise `z`.
- R6: `z` is never 1 in two consecutive cycles.
- R7: The stream 1 0 0 1 0 1 0 1 0 1 1 0 1 1 applied after reset gives `z` = 0 0 0 0 0 1 0 1 0 1 0 0 1 0. Each value is sampled in the cycle after its bit is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the input bit is accepted on the rising edge |
| rst | input | 1 | Synchronous active-high reset to IDLE |
| x | input | 1 | Serial data bit, one per clock |
| z | output | 1 | Match flag, high in FOUND only |

## Verification
The block has no tunable parameters: the state width and the pattern are fixed. The bench therefore builds the single default configuration. This one build reaches all four states and every one of the eight transitions, including both exits from FOUND that carry overlapping matches, and a reset in the middle of a partial match. A long pseudo-random stream is compared against a three-bit history model. That comparison covers transitions that the directed streams do not order explicitly.

// File: rtl/pd101_pkg.sv
`timescale 1ns/1ps
package pd101_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE  = 2'b00,
        ST_GOT1  = 2'b01,
        ST_GOT10 = 2'b10,
        ST_FOUND = 2'b11
    } pd_state_t;
endpackage

// File: rtl/pd101_next_state.sv
`timescale 1ns/1ps
module pd101_next_state
    import pd101_pkg::*;
(
    input  pd_state_t cur,
    input  logic      bit_in,
    output pd_state_t nxt
);
    always_comb begin
        unique case (cur)
            ST_IDLE:  nxt = bit_in ? ST_GOT1  : ST_IDLE;
            ST_GOT1:  nxt = bit_in ? ST_GOT1  : ST_GOT10;
            ST_GOT10: nxt = bit_in ? ST_FOUND : ST_IDLE;
            ST_FOUND: nxt = bit_in ? ST_GOT1  : ST_GOT10;
            default:  nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/pd101_out_decode.sv
`timescale 1ns/1ps
module pd101_out_decode
    import pd101_pkg::*;
(
    input  pd_state_t cur,
    output logic      flag
);
    always_comb begin
        unique case (cur)
            ST_FOUND: flag = 1'b1;
            ST_IDLE,
            ST_GOT1,
            ST_GOT10: flag = 1'b0;
            default:  flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/pd101_detector.sv
`timescale 1ns/1ps
module pd101_detector
    import pd101_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x,
    output logic z
);
    pd_state_t state_q;
    pd_state_t state_d;

    pd101_next_state u_next (
        .cur    (state_q),
        .bit_in (x),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    pd101_out_decode u_out (
        .cur  (state_q),
        .flag (z)
    );
endmodule

// File: rtl/pd101_checker.sv
`timescale 1ns/1ps
module pd101_checker
    import pd101_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      x,
    input logic      z,
    input pd_state_t state_q
);
    logic [2:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 3'b000;
        end else begin
            hist_q <= {hist_q[1:0], x};
        end
    end

    // R1
    p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state_q == ST_IDLE) && !z);

    // R2: the flag agrees with an independent history of accepted bits
    p_match_r2: assert property (@(posedge clk) disable iff (rst) z == (hist_q == 3'b101));

    // R3
    p_overlap_r3: assert property (@(posedge clk) disable iff (rst) (z && !x) ##1 x |=> z);

    // R4
    p_found_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FOUND && !x) |=> (state_q == ST_GOT10));
    p_found_one_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FOUND && x) |=> (state_q == ST_GOT1));

    // R5
    p_ones_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GOT1 && x) |=> (state_q == ST_GOT1));

    // R6
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst) z |=> !z);
endmodule

bind pd101_detector pd101_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .x       (x),
    .z       (z),
    .state_q (state_q)
);

// File: tb/pd101_detector_tb.sv
`timescale 1ns/1ps
module pd101_detector_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x   = 1'b0;
    logic z;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [2:0] model_h = 3'b000;

    always #10 clk = ~clk;

    pd101_detector u_dut (
        .clk (clk),
        .rst (rst),
        .x   (x),
        .z   (z)
    );

    task automatic check(input logic exp, input string req);
        n_checks++;
        if (z !== exp) begin
            n_fails++;
            $display("FAIL %s: z=%0b expected %0b at %0t", req, z, exp, $time);
        end
    endtask

    // Apply one bit (called at a negedge); check z one edge later.
    task automatic step(input logic b, input logic exp, input string req);
        x = b;
        @(posedge clk);
        @(negedge clk);
        model_h = {model_h[1:0], b};
        check(exp, req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        x = 1'b1;
        @(posedge clk);
        @(negedge clk);
        model_h = 3'b000;
        check(1'b0, "R1 reset");
        rst = 1'b0;
    endtask

    task automatic test_reference_stream();
        logic [13:0] bits = 14'b10010101011011;
        logic [13:0] exps = 14'b00000101010010;
        do_reset();
        for (int i = 13; i >= 0; i--) step(bits[i], exps[i], "R7 reference stream");
    endtask

    task automatic test_overlap();
        do_reset();
        step(1, 0, "R3 overlap");
        step(0, 0, "R3 overlap");
        step(1, 1, "R3 first match");
        step(0, 0, "R3 overlap");
        step(1, 1, "R3 second match");
        step(1, 0, "R6 no double pulse");
    endtask

    task automatic test_found_exits();
        do_reset();
        step(1, 0, "R4 setup");
        step(0, 0, "R4 setup");
        step(1, 1, "R4 found");
        step(1, 0, "R4 found then 1");
        step(0, 0, "R4 got10");
        step(1, 1, "R4 found-1-0-1 rematch");
        step(0, 0, "R4 found then 0");
        step(0, 0, "R4 00 to idle");
        step(1, 0, "R4 no match after 00");
    endtask

    task automatic test_runs();
        do_reset();
        for (int i = 0; i < 6; i++) step(1, 0, "R5 ones run");
        for (int i = 0; i < 6; i++) step(0, 0, "R5 zeros run");
        step(1, 0, "R5 1001");
        step(0, 0, "R5 1001");
        step(0, 0, "R5 1001");
        step(1, 0, "R5 1001");
    endtask

    task automatic test_reset_mid();
        do_reset();
        step(1, 0, "R1 pre-reset");
        step(0, 0, "R1 pre-reset");
        do_reset();
        step(1, 0, "R1 history cleared");
        step(0, 0, "R1 after reset");
        step(1, 1, "R1 fresh match");
    endtask

    task automatic test_random();
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 400; i++) begin
            logic nb;
            logic [2:0] h;
            nb = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            h = {model_h[1:0], nb};
            step(nb, h == 3'b101, "R2 random stream");
        end
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        test_reference_stream();
        test_overlap();
        test_found_exits();
        test_runs();
        test_reset_mid();
        test_random();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule